// File: doc/BRIEF.md
# Tone-Pair Guard-Time Steering Controller

This block sits behind a dual-tone frequency classifier. It turns the classifier's raw "two valid tones present" indication into registered digits. Counters clocked by a reference tick do the work that an external resistor-capacitor timing network would otherwise do. A tone pair counts as a digit only after the presence indication has stayed high without a break for a programmable number of ticks. The digit ends only after the indication has stayed low without a break for a second, independent number of ticks. Short bursts are therefore rejected, and short dropouts inside a tone are bridged.

When a digit is accepted, the block captures the classifier's 4-bit code and raises its guard steering output. After a fixed settling delay it copies the captured code to the receive latch and raises the delayed steering flag. The flag is mirrored into a status vector. When interrupt mode is enabled, the flag also drives an active-low interrupt line. The receive latch is written only at the instant the delayed flag goes high.

Top module: `guard_steer`

## Requirements
- R1: After reset, gtSteer and dlyFlag are low, rxCode is 0, irqN is high and statusBits is 0.
- R2: gtSteer goes high at the clock edge that samples earlyValid high for the presentGuard-th consecutive time (a presentGuard of 0 acts as 1). A burst shorter than presentGuard consecutive high samples leaves every output unchanged.
- R3: The code is taken from candCode at the edge where gtSteer rises. Later changes of candCode do not alter the code that is later published.
- R4: dlyFlag rises exactly SETTLE_TICKS edges after gtSteer rises. rxCode takes the captured code at that same edge and changes at no other edge.
- R5: While gtSteer is high, a run of fewer than absentGuard consecutive low samples of earlyValid has no effect: gtSteer and dlyFlag stay high, and no new code is captured or published.
- R6: At the edge that samples earlyValid low for the absentGuard-th consecutive time (0 acts as 1), gtSteer and dlyFlag both fall. Any later digit again needs presentGuard consecutive high samples.
- R7: If the pause is accepted before the settling delay has elapsed, dlyFlag never rises for that digit and rxCode keeps its previous value.
- R8: irqN is low exactly when irqEnable is high and dlyFlag is high. Bit 0 of statusBits is dlyFlag and bit 1 is gtSteer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference tick clock |
| rstN | input | 1 | Asynchronous active-low reset |
| earlyValid | input | 1 | Classifier reports a valid tone pair this tick |
| candCode | input | CODE_W | Code of the tone pair currently classified |
| presentGuard | input | GUARD_W | Ticks of continuous presence needed to accept a digit |
| absentGuard | input | GUARD_W | Ticks of continuous absence needed to accept a pause |
| irqEnable | input | 1 | Selects interrupt mode |
| gtSteer | output | 1 | Guard-time steering output, high while a digit is held |
| rxCode | output | CODE_W | Receive data latch |
| dlyFlag | output | 1 | Delayed steering flag, a digit has been published |
| statusBits | output | 2 | {gtSteer, dlyFlag} status view |
| irqN | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with GUARD_W = 3 and SETTLE_TICKS = 2. It drives both guard times over every value from 1 to 5. For each pair it applies bursts one tick shorter than the presence guard, equal to it and longer than it. It also applies two-tone sequences whose gap sits one tick below, at and above the absence guard. These small values bring the cancelled-publication case (pause accepted before the settling delay ends) and the bridge-versus-split boundary within reach of every guard combination. At each tick the bench compares all outputs against windows it computes arithmetically.

// File: rtl/guard_steer_pkg.sv
package guard_steer_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HELD = 1'b1
  } steerState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrPresent;
    logic incPresent;
    logic capture;
    logic clrAbsent;
    logic incAbsent;
    logic endDigit;
    logic publish;
  } steerCmd_t;

endpackage

// File: rtl/guard_steer_dp.sv
module guard_steer_dp
  import guard_steer_pkg::*;
#(
  parameter int GUARD_W      = 8,
  parameter int CODE_W       = 4,
  parameter int SETTLE_TICKS = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  steerCmd_t          cmd,
  input  logic [CODE_W-1:0]  candCode,
  input  logic [GUARD_W-1:0] presentGuard,
  input  logic [GUARD_W-1:0] absentGuard,
  output logic               presentDone,
  output logic               absentDone,
  output logic               settleDone,
  output logic [CODE_W-1:0]  rxCode,
  output logic               dlyFlag
);

  localparam int SW = $clog2(SETTLE_TICKS + 1);
  localparam logic [SW-1:0]    SETTLE_LAST = SW'(SETTLE_TICKS - 1);
  localparam logic [GUARD_W:0] ONE_W = (GUARD_W + 1)'(1);

  logic [GUARD_W-1:0] presentCnt;
  logic [GUARD_W-1:0] absentCnt;
  logic [SW-1:0]      settleCnt;
  logic               armed;
  logic [CODE_W-1:0]  holdCode;

  // this edge completes the run when count+1 reaches the guard (0 acts as 1)
  assign presentDone = ({1'b0, presentCnt} + ONE_W) >= {1'b0, presentGuard};
  assign absentDone  = ({1'b0, absentCnt} + ONE_W) >= {1'b0, absentGuard};
  assign settleDone  = armed && (settleCnt == SETTLE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presentCnt <= '0;
      absentCnt  <= '0;
      settleCnt  <= '0;
      armed      <= 1'b0;
      holdCode   <= '0;
      rxCode     <= '0;
      dlyFlag    <= 1'b0;
    end else begin
      if (cmd.clrPresent || cmd.capture) presentCnt <= '0;
      else if (cmd.incPresent)           presentCnt <= presentCnt + 1'b1;

      if (cmd.clrAbsent || cmd.endDigit) absentCnt <= '0;
      else if (cmd.incAbsent)            absentCnt <= absentCnt + 1'b1;

      if (cmd.capture) begin
        holdCode  <= candCode;
        settleCnt <= '0;
        armed     <= 1'b1;
      end else if (cmd.endDigit || cmd.publish) begin
        armed <= 1'b0;
      end else if (armed) begin
        settleCnt <= settleCnt + 1'b1;
      end

      if (cmd.publish) rxCode <= holdCode;

      if (cmd.endDigit)     dlyFlag <= 1'b0;
      else if (cmd.publish) dlyFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/guard_steer_ctrl.sv
module guard_steer_ctrl
  import guard_steer_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      earlyValid,
  input  logic      presentDone,
  input  logic      absentDone,
  input  logic      settleDone,
  output steerCmd_t cmd,
  output logic      gtSteer
);

  steerState_t state, nextState;

  always_comb begin
    cmd       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (!earlyValid) begin
          cmd.clrPresent = 1'b1;
        end else if (presentDone) begin
          cmd.capture = 1'b1;
          nextState   = ST_HELD;
        end else begin
          cmd.incPresent = 1'b1;
        end
      end
      ST_HELD: begin
        if (earlyValid) begin
          cmd.clrAbsent = 1'b1;
        end else if (absentDone) begin
          cmd.endDigit = 1'b1;
          nextState    = ST_IDLE;
        end else begin
          cmd.incAbsent = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
    // a pause accepted at the same edge cancels publication
    cmd.publish = settleDone && !cmd.endDigit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign gtSteer = (state == ST_HELD);

endmodule

// File: rtl/guard_steer.sv
module guard_steer
  import guard_steer_pkg::*;
#(
  parameter int GUARD_W      = 8,
  parameter int CODE_W       = 4,
  parameter int SETTLE_TICKS = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               earlyValid,
  input  logic [CODE_W-1:0]  candCode,
  input  logic [GUARD_W-1:0] presentGuard,
  input  logic [GUARD_W-1:0] absentGuard,
  input  logic               irqEnable,
  output logic               gtSteer,
  output logic [CODE_W-1:0]  rxCode,
  output logic               dlyFlag,
  output logic [1:0]         statusBits,
  output logic               irqN
);

  steerCmd_t cmd;
  logic presentDone, absentDone, settleDone;

  guard_steer_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .earlyValid (earlyValid),
    .presentDone(presentDone),
    .absentDone (absentDone),
    .settleDone (settleDone),
    .cmd        (cmd),
    .gtSteer    (gtSteer)
  );

  guard_steer_dp #(
    .GUARD_W     (GUARD_W),
    .CODE_W      (CODE_W),
    .SETTLE_TICKS(SETTLE_TICKS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .candCode    (candCode),
    .presentGuard(presentGuard),
    .absentGuard (absentGuard),
    .presentDone (presentDone),
    .absentDone  (absentDone),
    .settleDone  (settleDone),
    .rxCode      (rxCode),
    .dlyFlag     (dlyFlag)
  );

  // R8: status view and interrupt
  assign statusBits = {gtSteer, dlyFlag};
  assign irqN       = ~(irqEnable & dlyFlag);

endmodule

// File: rtl/guard_steer_chk.sv
module guard_steer_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              earlyValid,
  input logic              irqEnable,
  input logic              gtSteer,
  input logic [CODE_W-1:0] rxCode,
  input logic              dlyFlag,
  input logic              irqN
);

  assert_rise_needs_tone_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gtSteer) |-> $past(earlyValid));

  assert_latch_only_on_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(dlyFlag) |-> $stable(rxCode));

  assert_flag_rise_while_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dlyFlag) |-> ($past(gtSteer) && gtSteer));

  assert_hold_while_tone_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(earlyValid) && $past(gtSteer) |-> gtSteer);

  assert_fall_needs_absence_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gtSteer) |-> (!$past(earlyValid) && !dlyFlag));

  assert_flag_within_digit_R6: assert property (@(posedge clk) disable iff (!rstN)
    dlyFlag |-> gtSteer);

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnable |-> irqN);

endmodule

bind guard_steer guard_steer_chk #(.CODE_W(CODE_W)) u_chk (.*);

// File: tb/sim_guard_steer.sv
`timescale 1ns/1ps
module sim_guard_steer;

  localparam int GW = 3;
  localparam int CW = 4;
  localparam int S  = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          earlyValid = 1'b0;
  logic [CW-1:0] candCode = '0;
  logic [GW-1:0] presentGuard = GW'(1);
  logic [GW-1:0] absentGuard = GW'(1);
  logic          irqEnable = 1'b0;
  logic          gtSteer, dlyFlag, irqN;
  logic [CW-1:0] rxCode;
  logic [1:0]    statusBits;

  int checks = 0;
  int fails = 0;
  logic [CW-1:0] expCode = '0;
  logic [CW-1:0] nextCodeVal = 4'h3;

  always #2.5 clk = ~clk;

  guard_steer #(.GUARD_W(GW), .CODE_W(CW), .SETTLE_TICKS(S)) u0 (
    .clk(clk), .rstN(rstN), .earlyValid(earlyValid), .candCode(candCode),
    .presentGuard(presentGuard), .absentGuard(absentGuard), .irqEnable(irqEnable),
    .gtSteer(gtSteer), .rxCode(rxCode), .dlyFlag(dlyFlag),
    .statusBits(statusBits), .irqN(irqN)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // one scenario: tone t1 ticks, gap d, second tone t2 (t2 == 0 means single tone)
  task automatic runScenario(input int p, input int a, input int t1, input int d,
                             input int t2, input logic [CW-1:0] codeA,
                             input logic [CW-1:0] codeB);
    bit reg1, reg2;
    int on1, off1, on2, off2, f1, f2, total, s;
    bit f1v, f2v;
    presentGuard = GW'(p);
    absentGuard  = GW'(a);
    irqEnable    = a[0];
    reg1 = (t1 >= p); reg2 = 1'b0;
    on1 = p; on2 = 0; off2 = 0; s = t1 + d;
    if (t2 == 0)   off1 = t1 + a;
    else if (d < a) off1 = t1 + d + t2 + a;   // bridged
    else begin
      off1 = t1 + a;
      reg2 = (t2 >= p);
      on2  = s + p;
      off2 = s + t2 + a;
    end
    f1 = on1 + S; f1v = reg1 && (f1 < off1);
    f2 = on2 + S; f2v = reg2 && (f2 < off2);
    total = (reg2 ? off2 : (reg1 ? off1 : t1 + d + t2 + 1)) + 4;
    for (int j = 0; j <= total; j++) begin
      @(negedge clk);
      if (j >= 1) begin
        bit eg, ef;
        eg = (reg1 && j >= on1 && j < off1) || (reg2 && j >= on2 && j < off2);
        ef = (f1v && j >= f1 && j < off1) || (f2v && j >= f2 && j < off2);
        if (f1v && j == f1) expCode = codeA;
        if (f2v && j == f2) expCode = codeB;
        // R2 R5 R6: steering window; R4 R7: flag window and latch; R3: code held
        chk("R2/R5/R6 gtSteer", int'(gtSteer), int'(eg));
        chk("R4/R7 dlyFlag", int'(dlyFlag), int'(ef));
        chk("R3/R4 rxCode", int'(rxCode), int'(expCode));
        chk("R8 irqN", int'(irqN), int'(!(irqEnable && ef)));
        chk("R8 statusBits", int'(statusBits), int'({eg, ef}));
      end
      begin
        int e;
        e = j + 1;
        if (e >= 1 && e <= t1) begin
          earlyValid = 1'b1;
          candCode   = (e > p) ? ~codeA : codeA;   // R3: change after capture
        end else if (t2 > 0 && e > s && e <= s + t2) begin
          earlyValid = 1'b1;
          candCode   = (e - s > p) ? ~codeB : codeB;
        end else begin
          earlyValid = 1'b0;
          candCode   = ~codeA;
        end
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 gtSteer", int'(gtSteer), 0);
    chk("R1 dlyFlag", int'(dlyFlag), 0);
    chk("R1 rxCode", int'(rxCode), 0);
    chk("R1 irqN", int'(irqN), 1);
    chk("R1 statusBits", int'(statusBits), 0);
    rstN = 1'b1;
    for (int p = 1; p <= 5; p++) begin
      for (int a = 1; a <= 5; a++) begin
        logic [CW-1:0] cA, cB;
        cA = nextCodeVal; cB = nextCodeVal + 4'h5;
        nextCodeVal = nextCodeVal + 4'h7;
        // R2 short burst, exact, long; R7 occurs where p + S >= t1 + a
        if (p > 1) runScenario(p, a, p - 1, 0, 0, cA, cB);
        runScenario(p, a, p, 0, 0, cA, cB);
        runScenario(p, a, p + 1, 0, 0, cB, cA);
        runScenario(p, a, p + 3, 0, 0, cA, cB);
        // R5 bridged dropout, R6 split at and above the absence guard
        if (a > 1) runScenario(p, a, p + S + 1, a - 1, p + 1, cA, cB);
        runScenario(p, a, p + S + 1, a, p + 1, cB, cA);
        runScenario(p, a, p + S + 1, a + 1, p + 1, cA, cB);
      end
    end
    summary();
    $finish;
  end

  initial begin
    #900000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

endmodule